// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 32 on-chip peripheral sources and drives a single combined interrupt line toward the host processor. Software reaches it through four word registers selected by a 2-bit address: a configuration word, a per-source enable mask, an in-service word and a vector word. Vector number 0 is reserved to mean "error", so source line 0 never raises a request.

A handler claims an interrupt by writing 1 to bit 0 of the vector word. The controller then picks the highest-priority eligible source, records it in the in-service word and latches its number. The handler reads that number back from bits 15:11 of the vector word. When it is done, the handler writes a 1 to that source's bit in the in-service word to end the interrupt. A source in service blocks itself and everything of lower priority, but a more urgent source can still interrupt it.

The priority order is normally by vector number, with the lowest number winning. A configuration field can raise one chosen source above all others. A group of four serial-channel sources is ranked inside its own band by per-channel slot fields. If a claim finds nothing eligible, for example because the source was masked after it raised its request, the claim returns the error vector and pulses a separate error line.

Top module: `vpic_top`

## Requirements
- R1: After reset the configuration, mask, in-service and vector words all read 0, and irq_o, err_irq_o and cpu_level_o are low.
- R2: Mask bit v (bit position 1<<v) set to 1 enables source v and 0 masks it; a pending but masked source never drives irq_o.
- R3: irq_o is high exactly when the global enable (configuration bit 7) is 1 and at least one unmasked, unblocked source other than 0 is pending.
- R4: Writing a word with bit 0 = 1 to the vector word (address 3) claims the winning source: the next read of address 3 returns its number in bits 15:11 (all other bits 0), and its bit in the in-service word (address 2) becomes 1.
- R5: Among eligible sources with no override, the lowest vector number wins the claim.
- R6: The source whose number is in configuration bits 4:0 outranks every other source, for both claim selection and blocking.
- R7: Serial channels c = 0..3 are sources SER_BASE+c (default 26..29). The 2-bit slot of channel c sits in configuration bits 17+2c:16+2c, and the channel ranks as vector SER_BASE+slot. A lower slot wins, and equal slots fall back to the lower vector.
- R8: While a source's in-service bit is 1, that source and every source of equal or lower priority cannot be claimed and do not drive irq_o; higher-priority sources can still be claimed (nesting).
- R9: Writing to the in-service word clears exactly the bits written as 1 and leaves the bits written as 0 unchanged.
- R10: A claim with no eligible source latches vector 0, leaves the in-service word unchanged and pulses err_irq_o high for exactly one cycle; source line 0 is ignored.
- R11: cpu_level_o shows configuration bits 15:13.
- R12: The configuration word (bits 23:16, 15:13, 7, 4:0) and the mask word read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NSRC | Level-sensitive requests, one per source vector |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Combined interrupt to the host |
| err_irq_o | output | 1 | One-cycle pulse on a claim that found no eligible source |
| cpu_level_o | output | 3 | Host interrupt level from the configuration word |

## Verification
The bench targets three cases. The first is a claim that races with masking: a design that ignored the mask at claim time would hand back the masked source's vector and set its in-service bit instead of returning vector 0 with an error pulse. Nested service is driven with one source held in service. A design that blocked by in-service bit alone would let lower sources through, and one that blocked everything would stall a more urgent request. The priority override and the serial slot fields are each set so that the winner differs from plain numeric order. The end-of-interrupt write is sent with zeros beside the ones, so that a design that overwrote the word instead of clearing single bits is exposed.

// File: rtl/vpic_pkg.sv
// Shared register addresses and field positions for the vectored
// peripheral interrupt controller. Assumes a 32-bit register bus and at
// most 32 sources, so a vector fits in 5 bits.
package vpic_pkg;

    typedef enum logic [1:0] {
        RA_CFG  = 2'd0,
        RA_MASK = 2'd1,
        RA_ISR  = 2'd2,
        RA_VEC  = 2'd3
    } reg_addr_e;

    localparam int CFG_HP_LSB   = 0;   // override source, 5 bits
    localparam int CFG_HP_W     = 5;
    localparam int CFG_GIE_BIT  = 7;   // global enable
    localparam int CFG_LVL_LSB  = 13;  // host interrupt level
    localparam int CFG_LVL_W    = 3;
    localparam int CFG_SLOT_LSB = 16;  // serial slot fields
    localparam int N_SER        = 4;
    localparam int SLOT_W       = 2;
    localparam int VEC_RD_LSB   = 11;  // vector position on read
    localparam int VEC_ERR      = 0;   // reserved error vector

endpackage

// File: rtl/vpic_regs.sv
// Register file of the controller: configuration fields, enable mask and
// in-service word. Assumes one bus access per cycle; in-service bits are
// set by the claim unit and cleared by a write-one-to-clear store.
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int VEC_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [1:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic [NSRC-1:0]           isr_set,
    output logic                      gie,
    output logic [VEC_W-1:0]          hp_vec,
    output logic [CFG_LVL_W-1:0]      lvl,
    output logic [N_SER*SLOT_W-1:0]   slot,
    output logic [NSRC-1:0]           mask,
    output logic [NSRC-1:0]           isr
);

    logic wr_cfg, wr_mask, wr_isr;
    logic [NSRC-1:0] isr_clr;

    // decode the register being written
    always_comb begin
        wr_cfg  = bus_we && (bus_addr == RA_CFG);
        wr_mask = bus_we && (bus_addr == RA_MASK);
        wr_isr  = bus_we && (bus_addr == RA_ISR);
        isr_clr = wr_isr ? bus_wdata[NSRC-1:0] : '0;
    end

    // configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie    <= 1'b0;
            hp_vec <= '0;
            lvl    <= '0;
            slot   <= '0;
        end else if (wr_cfg) begin
            gie    <= bus_wdata[CFG_GIE_BIT];
            hp_vec <= bus_wdata[CFG_HP_LSB +: VEC_W];
            lvl    <= bus_wdata[CFG_LVL_LSB +: CFG_LVL_W];
            slot   <= bus_wdata[CFG_SLOT_LSB +: N_SER*SLOT_W];
        end
    end

    // enable mask, all sources masked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_mask) begin
            mask <= bus_wdata[NSRC-1:0];
        end
    end

    // in-service word: set on claim, cleared bit by bit at end of interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr <= '0;
        end else begin
            isr <= (isr & ~isr_clr) | isr_set;
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata;

    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '0) && (isr == '0));

    assert_eoi_clears_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_isr |=> isr == ($past(isr) & ~$past(bus_wdata[NSRC-1:0])));

    assert_one_claim_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_set));

endmodule

// File: rtl/vpic_prio.sv
// Priority resolver. Builds a rank key per source (override bit, then the
// serial slot or plain vector), finds the most urgent in-service key, and
// picks the lowest-key eligible source. Assumes SER_BASE+N_SER <= NSRC.
module vpic_prio
    import vpic_pkg::*;
#(
    parameter int NSRC     = 32,
    parameter int VEC_W    = 5,
    parameter int SER_BASE = 26
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src,
    input  logic [NSRC-1:0]           mask,
    input  logic [NSRC-1:0]           isr,
    input  logic [VEC_W-1:0]          hp_vec,
    input  logic [N_SER*SLOT_W-1:0]   slot,
    output logic                      any_elig,
    output logic [VEC_W-1:0]          win_vec
);

    localparam int KEY_W = VEC_W + 2;
    localparam logic [KEY_W-1:0] KEY_NONE = {1'b1, {(KEY_W-1){1'b0}}};

    logic [KEY_W-1:0] key [NSRC];
    logic [KEY_W-1:0] ins_key;
    logic [KEY_W-1:0] best_key;
    logic [NSRC-1:0]  elig;

    for (genvar v = 0; v < NSRC; v++) begin : g_src
        logic [VEC_W-1:0] base;
        if ((v >= SER_BASE) && (v < SER_BASE + N_SER)) begin : g_ser
            // serial channel ranks by its slot inside the serial band
            assign base = VEC_W'(SER_BASE) + VEC_W'(slot[(v-SER_BASE)*SLOT_W +: SLOT_W]);
        end else begin : g_plain
            assign base = VEC_W'(v);
        end
        assign key[v] = {1'b0, (hp_vec != VEC_W'(v)), base};
        if (v == VEC_ERR) begin : g_err
            assign elig[v] = 1'b0;
        end else begin : g_req
            assign elig[v] = src[v] && mask[v] && (key[v] < ins_key);
        end
    end

    logic unused_err_src;
    assign unused_err_src = src[VEC_ERR] ^ mask[VEC_ERR];

    // most urgent key among sources currently in service
    always_comb begin
        ins_key = KEY_NONE;
        for (int v = 0; v < NSRC; v++) begin
            if (isr[v] && (key[v] < ins_key)) ins_key = key[v];
        end
    end

    // lowest key among eligible sources, ties to the lower vector
    always_comb begin
        best_key = KEY_NONE;
        win_vec  = '0;
        for (int v = 0; v < NSRC; v++) begin
            if (elig[v] && (key[v] < best_key)) begin
                best_key = key[v];
                win_vec  = VEC_W'(v);
            end
        end
        any_elig = |elig;
    end

    assert_winner_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_elig |-> src[win_vec] && mask[win_vec]);

    assert_in_service_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_elig |-> !isr[win_vec]);

endmodule

// File: rtl/vpic_ack.sv
// Claim unit. On a claim request it marks the winning source in service
// and latches its vector, or latches the error vector and pulses the error
// line when nothing is eligible. Assumes the claim is a single-cycle strobe.
module vpic_ack
    import vpic_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int VEC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_req,
    input  logic               any_elig,
    input  logic [VEC_W-1:0]   win_vec,
    output logic [VEC_W-1:0]   vec_q,
    output logic               err_pulse,
    output logic [NSRC-1:0]    isr_set
);

    // one-hot in-service set for a successful claim
    always_comb begin
        isr_set = '0;
        if (ack_req && any_elig) isr_set[win_vec] = 1'b1;
    end

    // latch claimed vector and flag an empty claim
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q     <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= ack_req && !any_elig;
            if (ack_req) vec_q <= any_elig ? win_vec : VEC_W'(VEC_ERR);
        end
    end

    assert_claim_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && any_elig) |=> (vec_q == $past(win_vec)) && !err_pulse);

    assert_empty_claim_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !any_elig) |=> err_pulse && (vec_q == VEC_W'(VEC_ERR)));

    assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && !$past(ack_req, 2)) |=> !err_pulse);

endmodule

// File: rtl/vpic_top.sv
// Vectored peripheral interrupt controller top. Connects the register
// file, priority resolver and claim unit, decodes the claim strobe and
// muxes register reads. Assumes NSRC <= 32.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NSRC     = 32,
    parameter int SER_BASE = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              err_irq_o,
    output logic [2:0]        cpu_level_o
);

    localparam int VEC_W = $clog2(NSRC);

    logic                      gie;
    logic [VEC_W-1:0]          hp_vec;
    logic [CFG_LVL_W-1:0]      lvl;
    logic [N_SER*SLOT_W-1:0]   slot;
    logic [NSRC-1:0]           mask;
    logic [NSRC-1:0]           isr;
    logic [NSRC-1:0]           isr_set;
    logic                      any_elig;
    logic [VEC_W-1:0]          win_vec;
    logic [VEC_W-1:0]          vec_q;
    logic                      ack_req;

    // claim strobe: write of bit 0 to the vector word
    assign ack_req = bus_we && (bus_addr == RA_VEC) && bus_wdata[0];

    vpic_regs #(.NSRC(NSRC), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .isr_set(isr_set), .gie(gie), .hp_vec(hp_vec),
        .lvl(lvl), .slot(slot), .mask(mask), .isr(isr)
    );

    vpic_prio #(.NSRC(NSRC), .VEC_W(VEC_W), .SER_BASE(SER_BASE)) u_prio (
        .clk(clk), .rst_n(rst_n), .src(src_i), .mask(mask), .isr(isr),
        .hp_vec(hp_vec), .slot(slot), .any_elig(any_elig), .win_vec(win_vec)
    );

    vpic_ack #(.NSRC(NSRC), .VEC_W(VEC_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .any_elig(any_elig),
        .win_vec(win_vec), .vec_q(vec_q), .err_pulse(err_irq_o), .isr_set(isr_set)
    );

    // combined interrupt and level outputs
    assign irq_o       = gie && any_elig;
    assign cpu_level_o = lvl;

    // register read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CFG: begin
                bus_rdata[CFG_HP_LSB +: VEC_W]              = hp_vec;
                bus_rdata[CFG_GIE_BIT]                      = gie;
                bus_rdata[CFG_LVL_LSB +: CFG_LVL_W]         = lvl;
                bus_rdata[CFG_SLOT_LSB +: N_SER*SLOT_W]     = slot;
            end
            RA_MASK: bus_rdata[NSRC-1:0] = mask;
            RA_ISR:  bus_rdata[NSRC-1:0] = isr;
            default: bus_rdata[VEC_RD_LSB +: VEC_W] = vec_q;
        endcase
    end

    assert_irq_claim_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && irq_o) |=> !err_irq_o);

    assert_no_irq_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_CFG && !bus_wdata[CFG_GIE_BIT]) |=> !irq_o);

endmodule

// File: tb/test_vpic_top.sv
module test_vpic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, err_irq_o;
    logic [2:0]  cpu_level_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vpic_top i_vpic_top (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .err_irq_o(err_irq_o), .cpu_level_o(cpu_level_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_src(input logic [31:0] s);
        @(negedge clk);
        src_i = s;
        #1;
    endtask

    task automatic clear_all();
        set_src('0);
        wr(2'd1, '0);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, '0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R1 cfg", d, 0);
        rd(2'd1, d); chk("R1 mask", d, 0);
        rd(2'd2, d); chk("R1 isr", d, 0);
        rd(2'd3, d); chk("R1 vec", d, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 err", err_irq_o, 0);
        chk("R1 level", cpu_level_o, 0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] d;
        set_src(32'h20);
        wr(2'd0, 32'h80);
        chk("R2 masked source no irq", irq_o, 0);
        wr(2'd1, 32'h20);
        chk("R3 unmasked irq", irq_o, 1);
        rd(2'd1, d); chk("R12 mask readback", d, 32'h20);
        wr(2'd0, 32'h0);
        chk("R3 global enable off", irq_o, 0);
        clear_all();
    endtask

    task automatic t_claim_nest();
        logic [31:0] d;
        set_src(32'h220);
        wr(2'd0, 32'h80);
        wr(2'd1, 32'h220);
        chk("R3 irq with two pending", irq_o, 1);
        wr(2'd3, 32'h1);
        chk("R4 no err on good claim", err_irq_o, 0);
        rd(2'd3, d); chk("R5 lowest vector wins", d, 32'd5 << 11);
        rd(2'd2, d); chk("R4 in-service set", d, 32'h20);
        chk("R8 self and lower blocked", irq_o, 0);
        wr(2'd3, 32'h1);
        chk("R10 err pulse on empty claim", err_irq_o, 1);
        rd(2'd3, d); chk("R10 error vector", d, 0);
        rd(2'd2, d); chk("R10 in-service unchanged", d, 32'h20);
        @(negedge clk); #1;
        chk("R10 err pulse one cycle", err_irq_o, 0);
        set_src(32'h224);
        wr(2'd1, 32'h224);
        chk("R8 higher source nests", irq_o, 1);
        wr(2'd3, 32'h1);
        rd(2'd3, d); chk("R8 nested vector", d, 32'd2 << 11);
        rd(2'd2, d); chk("R8 nested in-service", d, 32'h24);
        wr(2'd2, 32'h0);
        rd(2'd2, d); chk("R9 zero write keeps bits", d, 32'h24);
        wr(2'd2, 32'h4);
        rd(2'd2, d); chk("R9 clears only written one", d, 32'h20);
        chk("R9 source 2 claimable again", irq_o, 1);
        clear_all();
    endtask

    task automatic t_override();
        logic [31:0] d;
        set_src(32'h0010_0008);
        wr(2'd1, 32'h0010_0008);
        wr(2'd0, 32'h80 | 32'd20);
        rd(2'd0, d); chk("R12 cfg readback", d, 32'h94);
        wr(2'd3, 32'h1);
        rd(2'd3, d); chk("R6 override wins", d, 32'd20 << 11);
        chk("R6 override blocks lower vectors", irq_o, 0);
        wr(2'd2, 32'h0010_0000);
        chk("R6 after end of override", irq_o, 1);
        wr(2'd0, 32'h80);
        wr(2'd3, 32'h1);
        rd(2'd3, d); chk("R5 plain order", d, 32'd3 << 11);
        clear_all();
    endtask

    task automatic t_serial();
        logic [31:0] d;
        set_src(32'h0C00_0000);
        wr(2'd1, 32'h0C00_0000);
        wr(2'd0, 32'h0006_0080);
        wr(2'd3, 32'h1);
        rd(2'd3, d); chk("R7 lower slot wins", d, 32'd27 << 11);
        wr(2'd2, 32'h0800_0000);
        wr(2'd0, 32'h80);
        wr(2'd3, 32'h1);
        rd(2'd3, d); chk("R7 equal slot ties to lower vector", d, 32'd26 << 11);
        clear_all();
    endtask

    task automatic t_race();
        logic [31:0] d;
        set_src(32'h80);
        wr(2'd0, 32'h80);
        wr(2'd1, 32'h80);
        chk("R2 enabled irq", irq_o, 1);
        wr(2'd1, 32'h0);
        chk("R2 masked drops irq", irq_o, 0);
        wr(2'd3, 32'h1);
        chk("R10 race err pulse", err_irq_o, 1);
        rd(2'd3, d); chk("R10 race error vector", d, 0);
        rd(2'd2, d); chk("R10 race no in-service", d, 0);
        set_src(32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        chk("R10 source zero ignored", irq_o, 0);
        clear_all();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(2'd0, 32'd5 << 13);
        chk("R11 level output", cpu_level_o, 5);
        rd(2'd0, d); chk("R12 level readback", d, 32'hA000);
        clear_all();
    endtask

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_mask_irq();
        t_claim_nest();
        t_override();
        t_serial();
        t_race();
        t_level();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule